// File: doc/BRIEF.md
# Non-stalling FIFO-write to dual AXI4-Stream splitter

This block sits between a producer that pushes packed multi-channel sample words through a FIFO-style write port and two downstream AXI4-Stream consumers. The producer cannot be stalled. Each word it offers is either taken or lost.

Every word is cut into equal lanes. By default a 64-bit word becomes two 32-bit lanes. Bits 31:0 feed stream A (lane 0) and bits 63:32 feed stream B (lane 1). Both lanes load in the same cycle.

Each lane has its own output register. That register holds valid, data and a sideband sync bit until the consumer on that lane takes the word. The sync bit copies the producer's flag, which marks that the first enabled channel sits in the first sample slot of the word.

A write that reaches a lane whose previous word is still waiting is dropped on that lane. The drop raises that lane's overflow pulse and sets a shared sticky overflow flag. The flag stays set until a one-cycle clear.

Top module: `fifo_axis_splitter`

## Requirements
- R1: A synchronous active-high reset clears every m_tvalid bit, every m_tuser bit, every ovf_lane bit and ovf_sticky on the next clock edge.
- R2: When wr_en is high and lane i has no pending word, in the next cycle m_tvalid[i] is 1 and lane i shows wr_data bits [32*i+31 : 32*i]. Lane 0 takes bits 31:0 and lane 1 takes bits 63:32.
- R3: The m_tuser bit of every lane that takes a word equals the wr_sync value sampled with that word.
- R4: While m_tvalid[i] is 1 and m_tready[i] is 0, lane i keeps valid, data and m_tuser unchanged in the next cycle.
- R5: When a lane hands over its word (valid and ready both high) and wr_en is low, that lane's valid is 0 in the next cycle.
- R6: When a lane hands over its word in the same cycle that wr_en is high, the new word is loaded with no gap, so valid stays 1 and the data changes.
- R7: A write while lane i is pending (valid high, ready low) is dropped on lane i only. ovf_lane[i] is 1 for exactly the following cycle. The other lanes behave as if they were alone.
- R8: ovf_sticky becomes 1 in the cycle after any lane drops a word. It stays 1 until ovf_clear is high at a clock edge with no drop in that same cycle. A drop in the clear cycle keeps the flag set.
- R9: While wr_en is low, no lane loads a word and no overflow is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Producer write strobe; a word is offered when high |
| wr_data | input | 64 | Packed sample word |
| wr_sync | input | 1 | Marks that the first enabled channel is in the first slot |
| ovf_clear | input | 1 | One-cycle pulse that clears the sticky overflow flag |
| m_tvalid | output | 2 | Per-lane stream valid (bit 0 = A, bit 1 = B) |
| m_tdata | output | 64 | Per-lane stream data, lane i at [32*i +: 32] |
| m_tuser | output | 2 | Per-lane sideband sync bit |
| m_tready | input | 2 | Per-lane stream ready |
| ovf_lane | output | 2 | Per-lane one-cycle pulse for a dropped word |
| ovf_sticky | output | 1 | Shared sticky overflow flag |

## Verification
Three kinds of traffic are driven into the block. Steady writes with both readies high, sync toggling and wr_en gaps separate correct lane slicing and sync carrying from unwanted loads while idle. Holding one lane's ready low while writing back to back shows that a drop stays on that lane and leaves the other untouched. It also shows the held word staying stable and the clear/drop priority of the sticky flag. A long stretch of random writes, readies and clears is compared every cycle against a behavioural model. That stretch covers hand-over and reload in the same cycle, which directed tests miss.

// File: rtl/fax_pkg.sv
package fax_pkg;
  parameter int unsigned FAX_WORD_W = 64;
  parameter int unsigned FAX_LANES  = 2;

  function automatic int unsigned fax_lane_w(input int unsigned word_w, input int unsigned lanes);
    return word_w / lanes;
  endfunction
endpackage

// File: rtl/fax_lane_slot.sv
module fax_lane_slot #(
  parameter int unsigned LANE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] wr_slice,
  input  logic              wr_sync,
  input  logic              ready,
  output logic              valid,
  output logic [LANE_W-1:0] data,
  output logic              user,
  output logic              lost,
  output logic              ovf_pulse
);
  logic pending;
  logic take;

  assign pending = valid & ~ready;
  assign take    = wr_en & ~pending;
  assign lost    = wr_en & pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= 1'b0;
      user      <= 1'b0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= lost;
      if (take) begin
        valid <= 1'b1;
        user  <= wr_sync;
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) data <= wr_slice;
  end
endmodule

// File: rtl/fax_ovf_track.sv
module fax_ovf_track #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lost,
  input  logic             clear,
  output logic             sticky
);
  logic any_lost;
  assign any_lost = |lost;

  always_ff @(posedge clk) begin
    if (rst) sticky <= 1'b0;
    else     sticky <= (sticky & ~clear) | any_lost;
  end
endmodule

// File: rtl/fifo_axis_splitter.sv
module fifo_axis_splitter
  import fax_pkg::*;
#(
  parameter int unsigned WORD_W = FAX_WORD_W,
  parameter int unsigned LANES  = FAX_LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_sync,
  input  logic              ovf_clear,
  output logic [LANES-1:0]  m_tvalid,
  output logic [WORD_W-1:0] m_tdata,
  output logic [LANES-1:0]  m_tuser,
  input  logic [LANES-1:0]  m_tready,
  output logic [LANES-1:0]  ovf_lane,
  output logic              ovf_sticky
);
  localparam int unsigned LANE_W = fax_lane_w(WORD_W, LANES);

  logic [LANES-1:0] lane_lost;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fax_lane_slot #(.LANE_W(LANE_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_slice  (wr_data[g*LANE_W +: LANE_W]),
      .wr_sync   (wr_sync),
      .ready     (m_tready[g]),
      .valid     (m_tvalid[g]),
      .data      (m_tdata[g*LANE_W +: LANE_W]),
      .user      (m_tuser[g]),
      .lost      (lane_lost[g]),
      .ovf_pulse (ovf_lane[g])
    );
  end

  fax_ovf_track #(.LANES(LANES)) u_track (
    .clk    (clk),
    .rst    (rst),
    .lost   (lane_lost),
    .clear  (ovf_clear),
    .sticky (ovf_sticky)
  );
endmodule

// File: rtl/fifo_axis_splitter_chk.sv
module fifo_axis_splitter_chk #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned LANES  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              ovf_clear,
  input logic [LANES-1:0]  m_tvalid,
  input logic [WORD_W-1:0] m_tdata,
  input logic [LANES-1:0]  m_tuser,
  input logic [LANES-1:0]  m_tready,
  input logic [LANES-1:0]  ovf_lane,
  input logic              ovf_sticky
);
  localparam int unsigned LW = WORD_W / LANES;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (m_tvalid == '0 && m_tuser == '0 && ovf_lane == '0 && !ovf_sticky));

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_sticky && !ovf_clear) |=> ovf_sticky);

  // R8
  sticky_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_lane != '0) |-> ovf_sticky);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (ovf_lane == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid[g] && !m_tready[g]) |=>
        (m_tvalid[g] && $stable(m_tdata[g*LW +: LW]) && $stable(m_tuser[g])));
    // R5
    drain_chk: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid[g] && m_tready[g] && !wr_en) |=> !m_tvalid[g]);
    // R7
    lane_ovf_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && m_tvalid[g] && !m_tready[g]) |=> ovf_lane[g]);
    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !(m_tvalid[g] && !m_tready[g])) |=> (m_tvalid[g] && !ovf_lane[g]));
  end
endmodule

bind fifo_axis_splitter fifo_axis_splitter_chk #(.WORD_W(WORD_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .ovf_clear  (ovf_clear),
  .m_tvalid   (m_tvalid),
  .m_tdata    (m_tdata),
  .m_tuser    (m_tuser),
  .m_tready   (m_tready),
  .ovf_lane   (ovf_lane),
  .ovf_sticky (ovf_sticky)
);

// File: tb/fifo_axis_splitter_test.sv
module fifo_axis_splitter_test;
  localparam int W = 64;
  localparam int L = 2;
  localparam int LW = W / L;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic wr_sync = 1'b0;
  logic ovf_clear = 1'b0;
  logic [L-1:0] m_tready = '0;
  logic [L-1:0] m_tvalid;
  logic [W-1:0] m_tdata;
  logic [L-1:0] m_tuser;
  logic [L-1:0] ovf_lane;
  logic ovf_sticky;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";

  // behavioural reference state
  bit mv [L];
  bit [LW-1:0] md [L];
  bit mu [L];
  bit mo [L];
  bit ms;

  always #2 clk = ~clk;

  fifo_axis_splitter uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_sync(wr_sync),
    .ovf_clear(ovf_clear), .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tuser(m_tuser),
    .m_tready(m_tready), .ovf_lane(ovf_lane), .ovf_sticky(ovf_sticky)
  );

  always @(posedge clk) begin
    bit any;
    any = 0;
    cycles++;
    if (rst) begin
      for (int i = 0; i < L; i++) begin mv[i] = 0; mu[i] = 0; mo[i] = 0; end
      ms = 0;
    end else begin
      for (int i = 0; i < L; i++) begin
        bit busy;
        busy = mv[i] && !m_tready[i];
        mo[i] = wr_en && busy;
        any |= mo[i];
        if (wr_en && !busy) begin
          mv[i] = 1; md[i] = wr_data[i*LW +: LW]; mu[i] = wr_sync;
        end else if (mv[i] && m_tready[i]) begin
          mv[i] = 0;
        end
      end
      ms = (ms && !ovf_clear) || any;
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 0) begin
      for (int i = 0; i < L; i++) begin
        chk($sformatf("valid lane %0d", i), 64'(m_tvalid[i]), 64'(mv[i]));
        chk($sformatf("user lane %0d", i), 64'(m_tuser[i]), 64'(mu[i]));
        chk($sformatf("ovf lane %0d", i), 64'(ovf_lane[i]), 64'(mo[i]));
        if (mv[i]) chk($sformatf("data lane %0d", i), 64'(m_tdata[i*LW +: LW]), 64'(md[i]));
      end
      chk("sticky", 64'(ovf_sticky), 64'(ms));
    end
  end

  task automatic step(input bit we, input logic [W-1:0] d, input bit s,
                      input logic [L-1:0] rdy, input bit clr);
    @(negedge clk);
    #1;
    wr_en = we; wr_data = d; wr_sync = s; m_tready = rdy; ovf_clear = clr;
  endtask

  initial begin
    #(4 * 30000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1 reset
    tag = "R1";
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 2'b00, 0);
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 2'b00, 0);
    rst = 0;
    step(0, '0, 0, 2'b11, 0);
    @(negedge clk); #1;
    chk("R1 valids after reset", 64'(m_tvalid), 64'd0);
    chk("R1 sticky after reset", 64'(ovf_sticky), 64'd0);
    // R2 R3 slicing and sync, R6 back to back
    tag = "R2";
    step(1, 64'h1111_2222_3333_4444, 1, 2'b11, 0);
    tag = "R3";
    step(1, 64'hAAAA_BBBB_CCCC_DDDD, 0, 2'b11, 0);
    tag = "R6";
    step(1, 64'h0123_4567_89AB_CDEF, 1, 2'b11, 0);
    @(negedge clk); #1;
    chk("R6 back-to-back lane0", 64'(m_tdata[31:0]), 64'h89AB_CDEF);
    chk("R2 lane1 slice", 64'(m_tdata[63:32]), 64'h0123_4567);
    chk("R3 sync carried", 64'(m_tuser), 64'h3);
    // R5 drain, R9 idle
    tag = "R5";
    step(0, 64'hDEAD_BEEF_DEAD_BEEF, 1, 2'b11, 0);
    tag = "R9";
    step(0, 64'h5555_5555_5555_5555, 1, 2'b11, 0);
    step(0, 64'h5555_5555_5555_5555, 1, 2'b00, 0);
    @(negedge clk); #1;
    chk("R9 nothing loaded while idle", 64'(m_tvalid), 64'd0);
    // R4 R7 lane B stalled
    tag = "R4";
    step(1, 64'h0000_00B1_0000_00A1, 1, 2'b01, 0);
    tag = "R7";
    step(1, 64'h0000_00B2_0000_00A2, 0, 2'b01, 0);
    step(1, 64'h0000_00B3_0000_00A3, 0, 2'b01, 0);
    @(negedge clk); #1;
    chk("R7 lane1 pulse", 64'(ovf_lane), 64'h2);
    chk("R4 lane1 held word", 64'(m_tdata[63:32]), 64'h0000_00B1);
    chk("R7 lane0 unaffected", 64'(m_tdata[31:0]), 64'h0000_00A3);
    // R8 sticky hold, clear with loss, plain clear
    tag = "R8";
    step(0, '0, 0, 2'b01, 0);
    step(0, '0, 0, 2'b01, 0);
    @(negedge clk); #1;
    chk("R8 sticky holds", 64'(ovf_sticky), 64'd1);
    step(1, 64'h77, 0, 2'b01, 1);
    @(negedge clk); #1;
    chk("R8 loss beats clear", 64'(ovf_sticky), 64'd1);
    step(0, '0, 0, 2'b11, 1);
    @(negedge clk); #1;
    chk("R8 cleared", 64'(ovf_sticky), 64'd0);
    // random traffic compared every cycle
    tag = "R6";
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 4) != 0, {$urandom, $urandom}, $urandom % 2,
           L'($urandom % 4), ($urandom % 16) == 0);
    end
    tag = "R1";
    rst = 1;
    step(0, '0, 0, 2'b00, 0);
    step(0, '0, 0, 2'b00, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule